// File: doc/BRIEF.md
# SPI Master Controller with Mode-Fault Detection

The block is a serial-peripheral-interface master that sends 8-bit words written by software into a transmit holding register. Each word carries a 2-bit target index that picks one of four active-low chip-select outputs. Bits go out MSB first in clock mode 0: the serial clock idles low, data changes on the falling edge, and the input line is sampled on the rising edge. The received word is stored for software to read. The serial clock runs at a fixed integer division of the system clock, set by the `HALF` parameter (system cycles per half period).

Two programmable gaps shape the chip-select timing. The transfer gap follows every word. The select gap is inserted whenever the target changes, and during it no select is active. A hold option keeps the select low after a word, so consecutive words to the same target run without a release.

The shared select input is watched for another master driving it low. While the block is enabled and detection is on, a low level on that input sets a sticky fault flag and turns the block off. The fault also aborts the current word, parks the serial clock low and releases every select. Software clears the flag by reading status and restarts the block by writing the enable bit.

Top module: `spim_core`

## Requirements
- R1: After reset, all of `cs_n` are high, `sck` is low, the block is disabled, the fault flag is 0 and the transmit-empty flag is 1, so `status_o` = 4'b0001. The bit order of `status_o` and of the status register is: bit0 transmit-empty, bit1 fault, bit2 enabled, bit3 busy.
- R2: Writing address 3 queues a word, with data in bits 7:0 and the target index in bits 9:8. The word is shifted MSB first on `mosi` in mode 0 while `cs_n[target]` is low. The 8 bits sampled from `miso` can then be read at address 4, in bits 7:0.
- R3: The transmit-empty flag falls in the cycle after an address-3 write. It rises again, with busy, in the cycle the word moves into the shifter. If the block is idle and enabled, that is the next cycle.
- R4: The transfer gap sits in bits 15:8 of the mode register (address 1). With the hold bit (bit 1) at 0, the select is released after each word. Before it is asserted again for the same target, it stays high for at least max(gap,1) system cycles.
- R5: With the hold bit at 1, the select stays low after a word. A following word to the same target starts with no release in between.
- R6: The select gap sits in bits 23:16 of the mode register. When the target changes, all selects are high for at least max(gap,1) system cycles before the new one goes low.
- R7: The block may be enabled with detection on and `nss_in` driven low. The low level then passes a two-flop synchronizer, and on the third rising clock edge the fault flag is set and the block disables itself. At the same edge the word in flight is aborted, `sck` goes low and all selects go high.
- R8: The fault flag stays set until the status register (address 2) is read. That read returns 1 in bit 1, and the flag is 0 afterwards.
- R9: After a fault, queued words are not sent. The block resumes only after a write of 1 to bit 0 of the control register (address 0). Bit 1 of that register disables the block.
- R10: Detection is on after reset. Bit 0 of the mode register set to 1 turns it off. A low `nss_in` is also ignored while the block is disabled.
- R11: At most one chip select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_re` |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |
| nss_in | input | 1 | Shared select input watched for another master |
| status_o | output | 4 | {busy, enabled, fault, transmit-empty} |

## Verification
Register writes show up on `status_o` one cycle later, and read data appears one cycle after the strobe. The bench drives strobes on falling edges and samples on the following falling edge. The transmit-empty flag is checked in the cycle right after the write, where it must be low, and in the cycle after that, where it must be high together with busy. The fault is checked exactly: the flag must still be clear two cycles after `nss_in` falls and must be set in the third cycle. The select gaps depend on when software queues the next word, so they are checked as lower bounds, counted by a monitor of cycles with all selects high. Serial data is compared only once busy has dropped.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SELGAP = 2'd1,
    ST_SHIFT  = 2'd2,
    ST_XGAP   = 2'd3
  } spim_state_e;

  // register addresses
  localparam int A_CTRL = 0;
  localparam int A_MODE = 1;
  localparam int A_STAT = 2;
  localparam int A_TXD  = 3;
  localparam int A_RXD  = 4;

  // control bits
  localparam int C_EN  = 0;
  localparam int C_DIS = 1;

  // mode bits
  localparam int M_FDIS = 0;
  localparam int M_HOLD = 1;
  localparam int M_XLO  = 8;

  // status bits
  localparam int S_TXE = 0;
  localparam int S_FLT = 1;
  localparam int S_EN  = 2;
  localparam int S_BSY = 3;
endpackage

// File: rtl/spim_sync.sv
module spim_sync #(
  parameter int STG = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STG-1:0] ff_q;

  always_ff @(posedge clk) begin
    if (rst) ff_q <= '1;
    else     ff_q <= {ff_q[STG-2:0], d};
  end

  assign q = ff_q[STG-1];
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int DW   = 8,
  parameter int HALF = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic [DW-1:0] din,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] dout
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [DW-1:0] tx_q, rx_q;
  logic [CW-1:0] bit_q;
  logic [HW-1:0] div_q;
  logic          run_q, sck_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
      run_q  <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        run_q <= 1'b0;
        sck_q <= 1'b0;
        div_q <= '0;
      end else if (start) begin
        run_q <= 1'b1;
        tx_q  <= din;
        sck_q <= 1'b0;
        div_q <= '0;
        bit_q <= '0;
      end else if (run_q) begin
        if (div_q == HW'(HALF - 1)) begin
          div_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[DW-2:0], miso};
          end else begin
            sck_q <= 1'b0;
            if (bit_q == CW'(DW - 1)) begin
              run_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + CW'(1);
              tx_q  <= {tx_q[DW-2:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + HW'(1);
        end
      end
    end
  end

  assign sck  = sck_q;
  assign mosi = tx_q[DW-1];
  assign done = done_q;
  assign dout = rx_q;
endmodule

// File: rtl/spim_core.sv
module spim_core
  import spim_pkg::*;
#(
  parameter int DW   = 8,
  parameter int HALF = 2,
  parameter int GW   = 8,
  parameter int NCS  = 4,
  parameter int AW   = 3,
  parameter int RW   = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [AW-1:0] reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  output logic [NCS-1:0] cs_n,
  input  logic          nss_in,
  output logic [3:0]    status_o
);
  localparam int SW  = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int SLO = M_XLO + GW;

  spim_state_e   st_q;
  logic          en_q, fdis_q, hold_q, full_q, fault_q, sel_ok_q, cs_on_q;
  logic [GW-1:0] xgap_q, sgap_q, cnt_q;
  logic [DW-1:0] tdr_q, cur_q, rx_q;
  logic [SW-1:0] tdt_q, act_q;
  logic [RW-1:0] rdata_q;

  // synchronized shared-select input
  logic nss_s;
  spim_sync #(.STG(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (nss_in),
    .q   (nss_s)
  );

  logic          sh_start, sh_abort, sh_done;
  logic [DW-1:0] sh_din, sh_dout;
  spim_shift #(.DW(DW), .HALF(HALF)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .start (sh_start),
    .abort (sh_abort),
    .din   (sh_din),
    .miso  (miso),
    .sck   (sck),
    .mosi  (mosi),
    .done  (sh_done),
    .dout  (sh_dout)
  );

  logic wr_ctrl, wr_mode, wr_txd, rd_stat;
  logic fault_evt, dis_req, kill, need_sel, go, sel_end;

  always_comb begin
    wr_ctrl   = reg_we && (reg_addr == AW'(A_CTRL));
    wr_mode   = reg_we && (reg_addr == AW'(A_MODE));
    wr_txd    = reg_we && (reg_addr == AW'(A_TXD));
    rd_stat   = reg_re && (reg_addr == AW'(A_STAT));
    fault_evt = en_q && !fdis_q && !nss_s;
    dis_req   = wr_ctrl && reg_wdata[C_DIS];
    kill      = fault_evt || dis_req;
    need_sel  = !sel_ok_q || (tdt_q != act_q);
    go        = (st_q == ST_IDLE) && en_q && full_q && !kill;
    sel_end   = (st_q == ST_SELGAP) && (cnt_q == GW'(1));
    sh_start  = (go && !need_sel) || (sel_end && !kill);
    sh_abort  = kill;
    sh_din    = (st_q == ST_IDLE) ? tdr_q : cur_q;
  end

  function automatic logic [GW-1:0] gap_ld(input logic [GW-1:0] v);
    return (v == '0) ? GW'(1) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      en_q     <= 1'b0;
      fdis_q   <= 1'b0;
      hold_q   <= 1'b0;
      full_q   <= 1'b0;
      fault_q  <= 1'b0;
      sel_ok_q <= 1'b0;
      cs_on_q  <= 1'b0;
      xgap_q   <= '0;
      sgap_q   <= '0;
      cnt_q    <= '0;
      tdr_q    <= '0;
      cur_q    <= '0;
      rx_q     <= '0;
      tdt_q    <= '0;
      act_q    <= '0;
    end else begin
      // sequencer
      if (kill) begin
        st_q    <= ST_IDLE;
        cs_on_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (go) begin
            cur_q  <= tdr_q;
            full_q <= 1'b0;
            if (need_sel) begin
              st_q     <= ST_SELGAP;
              cs_on_q  <= 1'b0;
              act_q    <= tdt_q;
              sel_ok_q <= 1'b1;
              cnt_q    <= gap_ld(sgap_q);
            end else begin
              st_q    <= ST_SHIFT;
              cs_on_q <= 1'b1;
            end
          end
          ST_SELGAP: begin
            if (sel_end) begin
              st_q    <= ST_SHIFT;
              cs_on_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q - GW'(1);
            end
          end
          ST_SHIFT: if (sh_done) begin
            rx_q    <= sh_dout;
            st_q    <= ST_XGAP;
            cs_on_q <= hold_q;
            cnt_q   <= gap_ld(xgap_q);
          end
          ST_XGAP: begin
            if (cnt_q == GW'(1)) st_q <= ST_IDLE;
            else                 cnt_q <= cnt_q - GW'(1);
          end
          default: st_q <= ST_IDLE;
        endcase
      end

      // enable and fault
      if (fault_evt) begin
        en_q    <= 1'b0;
        fault_q <= 1'b1;
      end else begin
        if (rd_stat) fault_q <= 1'b0;
        if (dis_req) en_q <= 1'b0;
        else if (wr_ctrl && reg_wdata[C_EN]) en_q <= 1'b1;
      end

      // software registers
      if (wr_mode) begin
        fdis_q <= reg_wdata[M_FDIS];
        hold_q <= reg_wdata[M_HOLD];
        xgap_q <= reg_wdata[M_XLO +: GW];
        sgap_q <= reg_wdata[SLO +: GW];
      end
      if (wr_txd) begin
        tdr_q  <= reg_wdata[DW-1:0];
        tdt_q  <= reg_wdata[DW +: SW];
        full_q <= 1'b1;
      end
    end
  end

  // decoded chip selects
  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_n[g] = !(cs_on_q && (act_q == SW'(g)));
  end

  always_comb begin
    status_o        = '0;
    status_o[S_TXE] = !full_q;
    status_o[S_FLT] = fault_q;
    status_o[S_EN]  = en_q;
    status_o[S_BSY] = (st_q != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_re) begin
      if (reg_addr == AW'(A_MODE))
        rdata_q <= RW'({sgap_q, xgap_q, 6'b0, hold_q, fdis_q});
      else if (reg_addr == AW'(A_STAT))
        rdata_q <= RW'(status_o);
      else if (reg_addr == AW'(A_RXD))
        rdata_q <= RW'(rx_q);
      else
        rdata_q <= '0;
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
  parameter int NCS = 4,
  parameter int AW  = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           reg_re,
  input logic [AW-1:0]  reg_addr,
  input logic           sck,
  input logic [NCS-1:0] cs_n,
  input logic [3:0]     status_o
);
  logic rd_stat;
  assign rd_stat = reg_re && (reg_addr == AW'(2));

  // R11
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (&cs_n) |-> !sck);

  // R7
  fault_park_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[1]) |-> ((&cs_n) && !sck && !status_o[2]));

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(status_o[1]) && !$past(rd_stat)) |-> status_o[1]);

  // R9
  off_no_select_chk: assert property (@(posedge clk) disable iff (rst)
    !status_o[2] |-> (&cs_n));
endmodule

bind spim_core spim_chk #(.NCS(NCS), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_re   (reg_re),
  .reg_addr (reg_addr),
  .sck      (sck),
  .cs_n     (cs_n),
  .status_o (status_o)
);

// File: tb/tb_spim_core.sv
module tb_spim_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sck, mosi, miso;
  logic [3:0]  cs_n;
  logic        nss_in = 1'b1;
  logic [3:0]  status_o;

  int errs = 0;
  int nchk = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spim_core dut (.*);

  // slave model, mode 0
  logic [7:0] slave_byte = '0;
  logic [7:0] mon = '0;
  int sidx = 0;
  int sbase = 0;
  always @(negedge sck) sidx <= sidx + 1;
  assign miso = slave_byte[7 - ((sidx - sbase) & 7)];
  always @(posedge sck) mon <= {mon[6:0], mosi};

  // select monitor
  int gap_run = 0, last_gap = 0, rels = 0, last_cs = -1;
  bit act = 0, prev_low = 0;
  always @(posedge clk) begin
    if (cs_n != 4'hF) begin
      if (gap_run != 0) last_gap <= gap_run;
      gap_run  <= 0;
      act      <= 1;
      prev_low <= 1;
      for (int i = 0; i < 4; i++) if (!cs_n[i]) last_cs <= i;
    end else begin
      if (act) gap_run <= gap_run + 1;
      if (prev_low) rels <= rels + 1;
      prev_low <= 0;
    end
  end

  function automatic int max1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint actv, input longint expv);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, actv, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_busy(input bit lvl);
    for (int n = 0; n < 5000; n++) begin
      if (status_o[3] == lvl) break;
      @(negedge clk);
    end
  endtask

  task automatic setmode(input bit fdis, input bit hold, input int xg, input int sg);
    wr(3'd1, {8'h0, 8'(sg), 8'(xg), 6'h0, hold, fdis});
  endtask

  int rel_start, rel_end;
  task automatic xfer(input int tgt, input logic [7:0] b, input logic [7:0] sb);
    logic [31:0] r;
    slave_byte = sb;
    sbase = sidx;
    wr(3'd3, {22'h0, 2'(tgt), b});
    chk(status_o[0] == 1'b0, "R3 txe low after write", status_o[0], 0);
    @(negedge clk);
    chk(status_o[0] && status_o[3], "R3 txe and busy at start", status_o, 4'b1xx1);
    rel_start = rels;
    wait_busy(1'b0);
    chk(mon == b, "R2 mosi word", mon, b);
    chk(last_cs == tgt, "R2 selected target", last_cs, tgt);
    rd(3'd4, r);
    chk(r[7:0] == sb, "R2 miso word", r[7:0], sb);
    rel_end = rels;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errs + 1, nchk + 1);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int prel, ptgt, pxg;
    bit phold;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 4'hF, "R1 selects high", cs_n, 4'hF);
    chk(sck == 1'b0, "R1 sck low", sck, 0);
    chk(status_o == 4'b0001, "R1 status", status_o, 4'b0001);

    wr(3'd0, 32'h1);
    chk(status_o[2] == 1'b1, "R9 enable write", status_o[2], 1);

    // R4 directed: release between words, gap 3
    setmode(0, 0, 3, 0);
    xfer(1, 8'hA5, 8'h3C);
    xfer(1, 8'h5A, 8'hC3);
    chk(last_gap >= 3, "R4 transfer gap", last_gap, 3);

    // R5 directed: hold same target
    setmode(0, 1, 0, 0);
    xfer(2, 8'h81, 8'h18);
    prel = rel_end;
    xfer(2, 8'h7E, 8'hE7);
    chk(rel_start == prel, "R5 no release", rel_start, prel);
    chk(cs_n == 4'b1011, "R5 select still held", cs_n, 4'b1011);

    // R6 directed: switch target with select gap 4
    setmode(0, 1, 0, 4);
    xfer(0, 8'hC9, 8'h9C);
    chk(last_gap >= 4, "R6 select gap", last_gap, 4);

    // random mix
    ptgt = 0; phold = 1; pxg = 0; prel = rel_end;
    for (int it = 0; it < 12; it++) begin
      int tgt, xg, sg;
      bit hold;
      logic [7:0] b, sb;
      tgt = $urandom_range(3, 0);
      hold = 1'($urandom_range(1, 0));
      xg = $urandom_range(5, 0);
      sg = $urandom_range(5, 0);
      b = 8'($urandom);
      sb = 8'($urandom);
      setmode(0, hold, xg, sg);
      xfer(tgt, b, sb);
      if (tgt != ptgt)
        chk(last_gap >= max1(sg), "R6 random select gap", last_gap, max1(sg));
      else if (!phold)
        chk(last_gap >= max1(pxg), "R4 random transfer gap", last_gap, max1(pxg));
      else
        chk(rel_start == prel, "R5 random hold", rel_start, prel);
      ptgt = tgt; phold = hold; pxg = xg; prel = rel_end;
    end

    // R7: fault during a transfer
    setmode(0, 0, 0, 0);
    slave_byte = 8'h00;
    sbase = sidx;
    wr(3'd3, {22'h0, 2'd1, 8'h96});
    repeat (8) @(negedge clk);
    chk(cs_n != 4'hF && status_o[3], "R7 word in flight", cs_n, 4'hD);
    nss_in = 1'b0;
    repeat (2) @(negedge clk);
    chk(status_o[1] == 1'b0, "R7 synchronizer delay", status_o[1], 0);
    @(negedge clk);
    chk(status_o[1] == 1'b1, "R7 fault flag", status_o[1], 1);
    chk(status_o[2] == 1'b0, "R7 self disable", status_o[2], 0);
    chk(cs_n == 4'hF, "R7 selects released", cs_n, 4'hF);
    chk(sck == 1'b0, "R7 sck parked", sck, 0);
    chk(status_o[3] == 1'b0, "R7 aborted", status_o[3], 0);

    // R9 / R8: no transfer until re-enable, flag sticky
    nss_in = 1'b1;
    wr(3'd3, {22'h0, 2'd2, 8'h3C});
    repeat (20) @(negedge clk);
    chk(status_o[3] == 1'b0 && cs_n == 4'hF, "R9 stays off", {status_o, cs_n}, 8'h0F);
    chk(status_o[1] == 1'b1, "R8 sticky flag", status_o[1], 1);
    rd(3'd2, r);
    chk(r[1] == 1'b1, "R8 read shows fault", r[1], 1);
    chk(status_o[1] == 1'b0, "R8 cleared by read", status_o[1], 0);
    slave_byte = 8'h55;
    sbase = sidx;
    wr(3'd0, 32'h1);
    wait_busy(1'b1);
    wait_busy(1'b0);
    chk(mon == 8'h3C, "R9 resumes after enable", mon, 8'h3C);

    // R10: detection off, and ignored while disabled
    setmode(1, 0, 0, 0);
    nss_in = 1'b0;
    xfer(3, 8'h0F, 8'hF0);
    chk(status_o[1] == 1'b0 && status_o[2] == 1'b1, "R10 detection off", status_o[2:1], 2'b10);
    nss_in = 1'b1;
    repeat (3) @(negedge clk);
    wr(3'd0, 32'h2);
    setmode(0, 0, 0, 0);
    nss_in = 1'b0;
    repeat (6) @(negedge clk);
    chk(status_o[1] == 1'b0, "R10 ignored while disabled", status_o[1], 0);
    chk(cs_n == 4'hF, "R11 no select while off", cs_n, 4'hF);
    nss_in = 1'b1;
    rd(3'd1, r);
    chk(r[1:0] == 2'b00, "R10 mode readback", r[1:0], 0);

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule